// File: doc/BRIEF.md
# Multiple-Input Signature Register

This block folds the responses that come out of many scan chains into a single fixed-width signature during logic self-test. It is built as a linear feedback shift register. Each accepted beat advances the register by one shift with feedback from its top stage. In the same step, the bit from every chain output is XORed into a stage. The register is never cleared between patterns. A whole self-test run of many patterns is compacted over time into one running value, and the self-test controller samples that value after the last unload.

Chain outputs enter as a stream beat on a valid/ready interface. A beat is the set of chain-output bits for one shift cycle, so valid plays the role of shift enable. The block never stalls a beat for its own reasons. Ready drops only in a cycle where the controller asserts init, because init owns the register in that cycle and the beat is refused. A producer that sees ready low must hold the beat and present it again. Every bit of an offered beat must be a known value: a single unknown bit would spoil the rest of the signature.

The signature width, the number of chains, the feedback polynomial and the start value are parameters. When there are more chains than stages, the chains wrap around the stages.

Top module: `misr_sig`

## Requirements
- R1: When init is high at a clock edge, the signature becomes INIT_VAL (all zeros by default) at that edge, whatever valid and the data hold.
- R2: When init is low and no beat is accepted (valid low), the signature keeps its value.
- R3: On an accepted beat (valid and ready both high, init low), the next signature is the current value shifted left by one with a 0 entering bit 0. If the old bit WIDTH-1 was 1, that result is XORed with POLY (default 32'h04C11DB7). It is then XORed with the folded beat.
- R4: In the folded beat, stage j is the XOR of every chain i with i mod WIDTH equal to j. For example, chain 32 lands on stage 0 and chain 39 on stage 7 with the defaults, and chains 0 and 32 set together cancel.
- R5: Ready is low exactly in cycles where init is high and high otherwise, so no beat is ever refused outside an init cycle.
- R6: Accumulation runs across any number of beats with no per-pattern clearing. After a long stream, the signature equals the R3 recurrence applied to every accepted beat in order.
- R7: After the asynchronous active-low reset, the signature is INIT_VAL and carries no unknown bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| init | input | 1 | Synchronous load of the start value |
| resp_valid | input | 1 | A beat of chain outputs is offered (shift enable) |
| resp_ready | output | 1 | The block accepts the offered beat |
| resp_data | input | CHAINS (40) | One bit per scan-chain output |
| signature | output | WIDTH (32) | Current register contents |

## Verification
On every cycle, the assertions check four behaviours: init taking over the register, the signature holding when idle, ready dropping only under init, and the register staying free of unknowns. They also check two anchor points of the step: the all-zero fixed point, and pure feedback from a lone top bit. The exact next-state arithmetic for arbitrary beats, the wrap-around of extra chains with its cancellation, and the agreement of a long accumulated stream with an independent model can only be shown by the bench's scenarios.

// File: rtl/misr_pkg.sv
package misr_pkg;
  localparam int DEF_WIDTH  = 32;
  localparam int DEF_CHAINS = 40;
  localparam logic [DEF_WIDTH-1:0] DEF_POLY = 32'h04C11DB7;

  typedef enum logic [1:0] {
    SRC_HOLD = 2'd0,
    SRC_INIT = 2'd1,
    SRC_STEP = 2'd2
  } next_src_e;
endpackage

// File: rtl/misr_fold.sv
module misr_fold #(
  parameter int WIDTH  = misr_pkg::DEF_WIDTH,
  parameter int CHAINS = misr_pkg::DEF_CHAINS
) (
  input  logic [CHAINS-1:0] chain_bits,
  output logic [WIDTH-1:0]  stage_bits
);
  localparam int LANES = (CHAINS + WIDTH - 1) / WIDTH;

  for (genvar j = 0; j < WIDTH; j++) begin : g_stage
    logic [LANES-1:0] lane_bits;
    for (genvar l = 0; l < LANES; l++) begin : g_lane
      if (l * WIDTH + j < CHAINS) begin : g_used
        assign lane_bits[l] = chain_bits[l * WIDTH + j];
      end else begin : g_pad
        assign lane_bits[l] = 1'b0;
      end
    end
    assign stage_bits[j] = ^lane_bits;
  end
endmodule

// File: rtl/misr_step.sv
module misr_step #(
  parameter int               WIDTH = misr_pkg::DEF_WIDTH,
  parameter logic [WIDTH-1:0] POLY  = misr_pkg::DEF_POLY
) (
  input  logic [WIDTH-1:0] cur,
  input  logic [WIDTH-1:0] inject,
  output logic [WIDTH-1:0] nxt
);
  logic [WIDTH-1:0] shifted;
  logic [WIDTH-1:0] feedback;

  assign shifted  = {cur[WIDTH-2:0], 1'b0};
  assign feedback = cur[WIDTH-1] ? POLY : '0;
  assign nxt      = shifted ^ feedback ^ inject;
endmodule

// File: rtl/misr_ctrl.sv
module misr_ctrl
  import misr_pkg::*;
(
  input  logic      init,
  input  logic      valid,
  output logic      ready,
  output next_src_e src
);
  assign ready = !init;

  always_comb begin
    if (init)       src = SRC_INIT;
    else if (valid) src = SRC_STEP;
    else            src = SRC_HOLD;
  end
endmodule

// File: rtl/misr_sig.sv
module misr_sig
  import misr_pkg::*;
#(
  parameter int               WIDTH    = DEF_WIDTH,
  parameter int               CHAINS   = DEF_CHAINS,
  parameter logic [WIDTH-1:0] POLY     = DEF_POLY,
  parameter logic [WIDTH-1:0] INIT_VAL = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              init,
  input  logic              resp_valid,
  output logic              resp_ready,
  input  logic [CHAINS-1:0] resp_data,
  output logic [WIDTH-1:0]  signature
);
  logic [WIDTH-1:0] state_q;
  logic [WIDTH-1:0] folded;
  logic [WIDTH-1:0] stepped;
  next_src_e        src;

  misr_ctrl u_ctrl (
    .init  (init),
    .valid (resp_valid),
    .ready (resp_ready),
    .src   (src)
  );

  misr_fold #(.WIDTH(WIDTH), .CHAINS(CHAINS)) u_fold (
    .chain_bits (resp_data),
    .stage_bits (folded)
  );

  misr_step #(.WIDTH(WIDTH), .POLY(POLY)) u_step (
    .cur    (state_q),
    .inject (folded),
    .nxt    (stepped)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= INIT_VAL;
    end else begin
      unique case (src)
        SRC_INIT: state_q <= INIT_VAL;
        SRC_STEP: state_q <= stepped;
        default:  state_q <= state_q;
      endcase
    end
  end

  assign signature = state_q;
endmodule

// File: rtl/misr_sig_chk.sv
module misr_sig_chk #(
  parameter int               WIDTH    = 32,
  parameter int               CHAINS   = 40,
  parameter logic [WIDTH-1:0] POLY     = 32'h04C11DB7,
  parameter logic [WIDTH-1:0] INIT_VAL = '0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              init,
  input logic              resp_valid,
  input logic              resp_ready,
  input logic [CHAINS-1:0] resp_data,
  input logic [WIDTH-1:0]  signature
);
  localparam logic [WIDTH-1:0] TOP_ONLY = {1'b1, {(WIDTH-1){1'b0}}};

  AST_INIT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    init |=> signature == INIT_VAL); // R1

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!init && !resp_valid) |=> $stable(signature)); // R2

  AST_ZERO_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    (!init && resp_valid && resp_ready && signature == '0 && resp_data == '0) |=> signature == '0); // R3

  AST_TOP_FEEDBACK: assert property (@(posedge clk) disable iff (!rst_n)
    (!init && resp_valid && resp_ready && signature == TOP_ONLY && resp_data == '0) |=> signature == POLY); // R3

  AST_READY_UNDER_INIT: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && !resp_ready) |-> init); // R5

  AST_SIG_KNOWN: assert property (@(posedge clk) disable iff (!rst_n)
    !$isunknown(signature)); // R7
endmodule

bind misr_sig misr_sig_chk #(
  .WIDTH(WIDTH), .CHAINS(CHAINS), .POLY(POLY), .INIT_VAL(INIT_VAL)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .init       (init),
  .resp_valid (resp_valid),
  .resp_ready (resp_ready),
  .resp_data  (resp_data),
  .signature  (signature)
);

// File: tb/test_misr_sig.sv
module test_misr_sig;
  localparam int               W    = 32;
  localparam int               CH   = 40;
  localparam logic [W-1:0]     POLY = 32'h04C11DB7;
  localparam int               NROW = 8;

  // row = {init, valid, data[CH-1:0]}
  localparam logic [CH+1:0] TBL [NROW] = '{
    {1'b0, 1'b1, 40'h00_8000_0000},
    {1'b0, 1'b1, 40'h00_0000_0000},
    {1'b0, 1'b0, 40'hFF_FFFF_FFFF},
    {1'b0, 1'b1, 40'h12_3456_789A},
    {1'b1, 1'b1, 40'hAB_CDEF_0123},
    {1'b0, 1'b1, 40'h01_0000_0001},
    {1'b0, 1'b1, 40'h80_0000_0000},
    {1'b0, 1'b1, 40'hFF_0000_00FF}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          init = 1'b0;
  logic          resp_valid = 1'b0;
  logic          resp_ready;
  logic [CH-1:0] resp_data = '0;
  logic [W-1:0]  signature;

  int checks = 0;
  int fails  = 0;
  logic [W-1:0] model = '0;
  logic         rdy_seen;

  always #5ns clk = ~clk;

  misr_sig i_misr_sig (
    .clk(clk), .rst_n(rst_n), .init(init), .resp_valid(resp_valid),
    .resp_ready(resp_ready), .resp_data(resp_data), .signature(signature)
  );

  function automatic logic [W-1:0] ref_step(logic [W-1:0] s, logic [CH-1:0] d);
    logic [W-1:0] f = '0;
    for (int i = 0; i < CH; i++) f[i % W] = f[i % W] ^ d[i];
    return {s[W-2:0], 1'b0} ^ (s[W-1] ? POLY : '0) ^ f;
  endfunction

  task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic beat(logic ini, logic vld, logic [CH-1:0] d);
    @(negedge clk);
    init = ini; resp_valid = vld; resp_data = d;
    #1 rdy_seen = resp_ready;
    if (ini) model = '0;
    else if (vld) model = ref_step(model, d);
    @(posedge clk);
    #2;
  endtask

  initial begin
    #1ms;
    fails++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R7 reset value", signature, '0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R5 ready after reset", {31'd0, resp_ready}, 32'd1);

    for (int r = 0; r < NROW; r++) begin
      beat(TBL[r][CH+1], TBL[r][CH], TBL[r][CH-1:0]);
      if (TBL[r][CH+1]) begin
        check("R1 init load", signature, model);
        check("R5 ready low under init", {31'd0, rdy_seen}, 32'd0);
      end else if (TBL[r][CH]) check("R3/R4 step row", signature, model);
      else check("R2 idle hold row", signature, model);
    end

    // R4 directed: chain 32 folds onto stage 0
    beat(1'b1, 1'b0, '0);
    beat(1'b0, 1'b1, 40'h01_0000_0000);
    check("R4 chain 32 to stage 0", signature, 32'h0000_0001);
    // R4 directed: chains 0 and 32 cancel, so only the shift applies
    beat(1'b0, 1'b1, 40'h01_0000_0001);
    check("R4 cancel chains 0 and 32", signature, 32'h0000_0002);

    // R2: idle with data toggling
    for (int k = 0; k < 5; k++) beat(1'b0, 1'b0, {8'hA5, 32'hDEAD_BEEF ^ k});
    check("R2 hold across idle cycles", signature, 32'h0000_0002);

    // R6: long accumulated stream, no clearing
    begin
      logic [63:0] x = 64'h9E37_79B9_7F4A_7C15;
      beat(1'b1, 1'b0, '0);
      for (int k = 0; k < 2000; k++) begin
        x = x ^ (x << 13); x = x ^ (x >> 7); x = x ^ (x << 17);
        beat(1'b0, (k % 7) != 3, x[CH-1:0]);
      end
      check("R6 long stream signature", signature, model);
      check("R5 ready after stream", {31'd0, resp_ready}, 32'd1);
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule